// File: doc/BRIEF.md
# DMA Channel Status and Byte-Count Tracker

This block holds the status flags and the remaining byte count for one DMA channel. It sits beside the channel's transfer engine. Software loads the byte count and clears the flags through a small write interface. The engine supplies:

- a start pulse,
- the source and destination transfer sizes and addresses,
- a channel-selected level,
- a per-beat completion strobe,
- read-phase and write-phase bus-error strobes.

The block checks the channel setup at two moments: when the byte count is written, and when a start arrives. A faulty setup raises a sticky configuration-error flag. Bus errors raise their own sticky flags and stop the channel.

While a transfer runs, the block counts the byte total down by the destination beat size. It also keeps three flags: request, busy and done. The `xfer_go` output tells the engine whether it may move data. A single 32-bit status word shows everything at once:

| Bits | Content |
|------|---------|
| 30 | configuration error |
| 29 | source (read-phase) bus error |
| 28 | destination (write-phase) bus error |
| 26 | request |
| 25 | busy |
| 24 | done |
| 19:0 | remaining byte count |
| 31, 27, 23:20 | always 0 |

Top module: `dma_chan_status`

## Requirements
- R1: After reset every flag, the byte count, `status_word` and `xfer_go` are 0.
- R2: A `bcr_wr` loads `wr_data[19:0]` into the count. If `wr_data[23:20]` is nonzero (value above 0xFFFFF), CE (bit 30) and DONE (bit 24) set on the next edge.
- R3: A start while the count is 0 sets CE and DONE, and the channel never becomes busy.
- R4: Size codes are 00 = 4 bytes, 01 = 1 byte, 10 = 2 bytes. Misalignment sets CE and DONE. At start, a count misaligned to either size, a source address misaligned to the source size, or a destination address misaligned to the destination size counts as misaligned. At `bcr_wr`, a written value misaligned to a valid current size counts as misaligned.
- R5: A start while either size field holds the code 11 sets CE and DONE. At `bcr_wr`, the code 11 is not checked.
- R6: `rd_bus_err` while busy sets BES (bit 29) and DONE, and clears busy, request and `xfer_go`. The count is left unchanged.
- R7: `wr_bus_err` while busy sets BED (bit 28) and DONE, and clears busy, request and `xfer_go`. The count is left unchanged.
- R8: `sts_wr` with `wr_data[24]` = 1 clears CE, BES, BED and DONE. The error flags clear by no other means. `sts_wr` with `wr_data[24]` = 0 changes nothing.
- R9: After an accepted start, REQ (bit 26) reads 1 while bytes remain and `chan_sel` is 0, and reads 0 while `chan_sel` is 1. BSY (bit 25) and `xfer_go` rise one edge after `chan_sel` is first seen high.
- R10: Each `beat_done` while busy and selected lowers the count by the destination size (4/1/2). When the count reaches 0, DONE sets and BSY and `xfer_go` drop on the same edge.
- R11: Bits 31, 27 and 23:20 of `status_word` always read 0.
- R12: A start while CE, BES or BED is set is refused. No request or busy follows, and the flags stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bcr_wr | input | 1 | Byte-count write strobe |
| sts_wr | input | 1 | Status write strobe (bit 24 = clear) |
| wr_data | input | 32 | Write data |
| start | input | 1 | Transfer start pulse |
| src_size | input | 2 | Source size code |
| dst_size | input | 2 | Destination size code |
| src_addr | input | 32 | Source address |
| dst_addr | input | 32 | Destination address |
| chan_sel | input | 1 | Channel selected by the engine |
| beat_done | input | 1 | One beat completed |
| rd_bus_err | input | 1 | Bus error in read phase |
| wr_bus_err | input | 1 | Bus error in write phase |
| status_word | output | 32 | Status flags and remaining count |
| xfer_go | output | 1 | Transfer may proceed |

## Verification
Countdowns run with each of the three size codes. This separates a correct per-size decrement from a fixed step, and shows that the completion edge drops busy. Each setup fault is injected on its own, with the other fields held valid:

- count too large,
- count zero at start,
- count, source address and destination address each misaligned,
- each size field set to code 11.

This shows which check raises the error and that the write-time and start-time checks differ. Read-phase and write-phase bus errors are injected in the middle of a transfer. This separates the two error flags and confirms the count freezes. Clearing is tried with bit 24 set and clear, and a start is attempted while an error is held.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

    localparam int CE_BIT   = 30;
    localparam int BES_BIT  = 29;
    localparam int BED_BIT  = 28;
    localparam int REQ_BIT  = 26;
    localparam int BSY_BIT  = 25;
    localparam int DONE_BIT = 24;

    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_HALF = 2'b10;
    localparam logic [1:0] SZ_RSVD = 2'b11;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            SZ_WORD: size_bytes = 3'd4;
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            default: size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dma_range_check.sv
module dma_range_check #(
    parameter int WR_W  = 24,
    parameter int CNT_W = 20
) (
    input  logic [WR_W-CNT_W-1:0] hi_bits,
    output logic                  over
);
    assign over = |hi_bits;
endmodule

// File: rtl/dma_align_check.sv
module dma_align_check
    import dma_stat_pkg::*;
(
    input  logic [1:0] lo,
    input  logic [1:0] size,
    output logic       misal
);
    always_comb begin
        case (size)
            SZ_WORD: misal = |lo;
            SZ_HALF: misal = lo[0];
            default: misal = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_beat_step.sv
module dma_beat_step
    import dma_stat_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       size,
    output logic [CNT_W-1:0] cnt_next,
    output logic             last
);
    logic [CNT_W-1:0] step;

    always_comb begin
        step = CNT_W'(size_bytes(size));
        if (cnt <= step) begin
            cnt_next = '0;
            last     = 1'b1;
        end else begin
            cnt_next = cnt - step;
            last     = 1'b0;
        end
    end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
    import dma_stat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 20,
    parameter int WR_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcr_wr,
    input  logic              sts_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              chan_sel,
    input  logic              beat_done,
    input  logic              rd_bus_err,
    input  logic              wr_bus_err,
    output logic [DATA_W-1:0] status_word,
    output logic              xfer_go
);
    localparam int N_ALIGN = 6;

    typedef struct packed {
        logic             ce;
        logic             bes;
        logic             bed;
        logic             done;
        logic             bsy;
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic               wr_over;
    logic [1:0]         al_lo   [N_ALIGN];
    logic [1:0]         al_sz   [N_ALIGN];
    logic [N_ALIGN-1:0] al_bad;
    logic [CNT_W-1:0]   cnt_dec;
    logic               cnt_last;
    logic               unused_bits;

    assign unused_bits = ^{wr_data[DATA_W-1:DONE_BIT+1],
                           src_addr[ADDR_W-1:2], dst_addr[ADDR_W-1:2]};

    dma_range_check #(.WR_W(WR_W), .CNT_W(CNT_W)) u_range (
        .hi_bits (wr_data[WR_W-1:CNT_W]),
        .over    (wr_over)
    );

    // 0..3: start-time checks, 4..5: write-time checks
    assign al_lo[0] = st_q.cnt[1:0];  assign al_sz[0] = src_size;
    assign al_lo[1] = st_q.cnt[1:0];  assign al_sz[1] = dst_size;
    assign al_lo[2] = src_addr[1:0];  assign al_sz[2] = src_size;
    assign al_lo[3] = dst_addr[1:0];  assign al_sz[3] = dst_size;
    assign al_lo[4] = wr_data[1:0];   assign al_sz[4] = src_size;
    assign al_lo[5] = wr_data[1:0];   assign al_sz[5] = dst_size;

    generate
        for (genvar g = 0; g < N_ALIGN; g++) begin : g_align
            dma_align_check u_al (
                .lo    (al_lo[g]),
                .size  (al_sz[g]),
                .misal (al_bad[g])
            );
        end
    endgenerate

    dma_beat_step #(.CNT_W(CNT_W)) u_step (
        .cnt      (st_q.cnt),
        .size     (dst_size),
        .cnt_next (cnt_dec),
        .last     (cnt_last)
    );

    logic err_any, start_try, start_bad, beat_ok, bus_err;

    always_comb begin
        st_d      = st_q;
        err_any   = st_q.ce | st_q.bes | st_q.bed;
        start_try = start & ~st_q.armed & ~err_any;
        start_bad = (st_q.cnt == '0) | (src_size == SZ_RSVD) |
                    (dst_size == SZ_RSVD) | (|al_bad[3:0]);
        bus_err   = st_q.bsy & (rd_bus_err | wr_bus_err);
        beat_ok   = st_q.bsy & chan_sel & beat_done & ~bus_err;

        if (sts_wr && wr_data[DONE_BIT]) begin
            st_d.ce   = 1'b0;
            st_d.bes  = 1'b0;
            st_d.bed  = 1'b0;
            st_d.done = 1'b0;
        end

        if (start_try) begin
            if (start_bad) begin
                st_d.ce   = 1'b1;
                st_d.done = 1'b1;
            end else begin
                st_d.armed = 1'b1;
            end
        end

        if (st_q.armed && chan_sel && !st_q.bsy)
            st_d.bsy = 1'b1;

        if (beat_ok) begin
            st_d.cnt = cnt_dec;
            if (cnt_last) begin
                st_d.done  = 1'b1;
                st_d.bsy   = 1'b0;
                st_d.armed = 1'b0;
            end
        end

        if (bus_err) begin
            st_d.bes   = st_q.bes | rd_bus_err;
            st_d.bed   = st_q.bed | wr_bus_err;
            st_d.done  = 1'b1;
            st_d.bsy   = 1'b0;
            st_d.armed = 1'b0;
        end

        if (bcr_wr) begin
            st_d.cnt = wr_data[CNT_W-1:0];
            if (wr_over || (|al_bad[5:4])) begin
                st_d.ce   = 1'b1;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_word                = '0;
        status_word[CE_BIT]        = st_q.ce;
        status_word[BES_BIT]       = st_q.bes;
        status_word[BED_BIT]       = st_q.bed;
        status_word[REQ_BIT]       = st_q.armed & (st_q.cnt != '0) & ~chan_sel;
        status_word[BSY_BIT]       = st_q.bsy;
        status_word[DONE_BIT]      = st_q.done;
        status_word[CNT_W-1:0]     = st_q.cnt;
    end

    assign xfer_go = st_q.bsy;

endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk
    import dma_stat_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bcr_wr,
    input logic        sts_wr,
    input logic [31:0] wr_data,
    input logic        chan_sel,
    input logic        beat_done,
    input logic        rd_bus_err,
    input logic        wr_bus_err,
    input logic [31:0] status_word,
    input logic        xfer_go
);
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[CE_BIT] && !(sts_wr && wr_data[DONE_BIT])) |=> status_word[CE_BIT])
        else $error("CE dropped without clear");

    p_req_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chan_sel |-> !status_word[REQ_BIT])
        else $error("REQ high while selected");

    p_bsy_after_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[BSY_BIT]) |-> $past(chan_sel))
        else $error("BSY rose without selection");

    p_bes_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[BSY_BIT] && rd_bus_err) |=> (status_word[BES_BIT] && !xfer_go))
        else $error("read bus error did not stop channel");

    p_bed_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[BSY_BIT] && wr_bus_err) |=> (status_word[BED_BIT] && !xfer_go))
        else $error("write bus error did not stop channel");

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[DONE_BIT]) |-> !status_word[BSY_BIT])
        else $error("DONE rose while busy");

    p_cnt_down_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[BSY_BIT] && chan_sel && beat_done && !rd_bus_err &&
         !wr_bus_err && !bcr_wr) |=> (status_word[19:0] < $past(status_word[19:0])))
        else $error("count did not fall on beat");

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[31] == 1'b0) && (status_word[27] == 1'b0) && (status_word[23:20] == 4'h0))
        else $error("reserved bit nonzero");
endmodule

bind dma_chan_status dma_chan_status_chk u_chk (.*);

// File: tb/dma_chan_status_tb_top.sv
`timescale 1ns/1ps
module dma_chan_status_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bcr_wr = 0, sts_wr = 0, start = 0;
    logic [31:0] wr_data = '0;
    logic [1:0]  src_size = 2'b00, dst_size = 2'b00;
    logic [31:0] src_addr = 32'h100, dst_addr = 32'h200;
    logic        chan_sel = 0, beat_done = 0, rd_bus_err = 0, wr_bus_err = 0;
    logic [31:0] status_word;
    logic        xfer_go;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_chan_status dut_i (
        .clk(clk), .rst_n(rst_n), .bcr_wr(bcr_wr), .sts_wr(sts_wr),
        .wr_data(wr_data), .start(start), .src_size(src_size),
        .dst_size(dst_size), .src_addr(src_addr), .dst_addr(dst_addr),
        .chan_sel(chan_sel), .beat_done(beat_done), .rd_bus_err(rd_bus_err),
        .wr_bus_err(wr_bus_err), .status_word(status_word), .xfer_go(xfer_go)
    );

    function automatic logic [31:0] ex(bit ce, bit bes, bit bed, bit req,
                                       bit bsy, bit done, logic [19:0] cnt);
        logic [31:0] v = '0;
        v[30] = ce; v[29] = bes; v[28] = bed; v[26] = req;
        v[25] = bsy; v[24] = done; v[19:0] = cnt;
        return v;
    endfunction

    function automatic int nbytes(logic [1:0] c);
        return (c == 2'b00) ? 4 : (c == 2'b01) ? 1 : 2;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bcr_write(input logic [31:0] v);
        wr_data = v; bcr_wr = 1; step(); bcr_wr = 0; wr_data = '0;
    endtask

    task automatic sts_write(input logic [31:0] v);
        wr_data = v; sts_wr = 1; step(); sts_wr = 0; wr_data = '0;
    endtask

    task automatic pulse_start();
        start = 1; step(); start = 0;
    endtask

    task automatic clear_all();
        sts_write(32'h0100_0000); bcr_write(32'h0);
        src_size = 2'b00; dst_size = 2'b00; src_addr = 32'h100; dst_addr = 32'h200;
    endtask

    task automatic t_reset();
        chk("R1 status after reset", status_word, 32'h0);
        chk("R1 go after reset", {31'h0, xfer_go}, 32'h0);
        chk("R11 reserved after reset", status_word & 32'h88F0_0000, 32'h0);
    endtask

    task automatic t_range();
        bcr_write(32'h0010_0000);
        chk("R2 over range", status_word, ex(1,0,0,0,0,1,20'h0));
        sts_write(32'h0);
        chk("R8 write zero keeps flags", status_word, ex(1,0,0,0,0,1,20'h0));
        sts_write(32'h0100_0000);
        chk("R8 clear", status_word, ex(0,0,0,0,0,0,20'h0));
        bcr_write(32'h000F_FFFC);
        chk("R2 max in range", status_word, ex(0,0,0,0,0,0,20'hFFFFC));
        clear_all();
    endtask

    task automatic t_zero_start();
        pulse_start();
        chk("R3 zero count start", status_word, ex(1,0,0,0,0,1,20'h0));
        chan_sel = 1; step();
        chk("R3 no busy", {status_word[25], xfer_go}, 32'h0);
        chan_sel = 0; clear_all();
    endtask

    task automatic t_align();
        bcr_write(32'h6);
        chk("R4 write misaligned count", status_word, ex(1,0,0,0,0,1,20'h6));
        clear_all();
        src_size = 2'b01; dst_size = 2'b01; bcr_write(32'h6);
        chk("R4 byte size accepts 6", status_word, ex(0,0,0,0,0,0,20'h6));
        src_size = 2'b00; pulse_start();
        chk("R4 start count vs src size", status_word, ex(1,0,0,0,0,1,20'h6));
        clear_all();
        bcr_write(32'h8); src_addr = 32'h102; pulse_start();
        chk("R4 src addr misaligned", status_word, ex(1,0,0,0,0,1,20'h8));
        clear_all();
        bcr_write(32'h8); dst_size = 2'b10; dst_addr = 32'h201; pulse_start();
        chk("R4 dst addr misaligned", status_word, ex(1,0,0,0,0,1,20'h8));
        clear_all();
    endtask

    task automatic t_badsize();
        src_size = 2'b11; bcr_write(32'h8);
        chk("R5 write ignores size 11", status_word, ex(0,0,0,0,0,0,20'h8));
        pulse_start();
        chk("R5 src size 11 at start", status_word, ex(1,0,0,0,0,1,20'h8));
        clear_all();
        bcr_write(32'h8); dst_size = 2'b11; pulse_start();
        chk("R5 dst size 11 at start", status_word, ex(1,0,0,0,0,1,20'h8));
        clear_all();
    endtask

    task automatic t_refuse();
        bcr_write(32'h0010_0000);
        bcr_write(32'h8);
        chk("R8 CE sticky over count write", status_word, ex(1,0,0,0,0,1,20'h8));
        pulse_start();
        chk("R12 start refused no REQ", status_word, ex(1,0,0,0,0,1,20'h8));
        chan_sel = 1; step();
        chk("R12 start refused no BSY", status_word, ex(1,0,0,0,0,1,20'h8));
        chan_sel = 0; clear_all();
    endtask

    task automatic t_bus_err(input bit rd);
        bcr_write(32'h10); pulse_start();
        chan_sel = 1; step();
        beat_done = 1; step(); beat_done = 0;
        chk(rd ? "R6 mid transfer" : "R7 mid transfer", status_word, ex(0,0,0,0,1,0,20'hC));
        if (rd) rd_bus_err = 1; else wr_bus_err = 1;
        beat_done = 1; step(); beat_done = 0; rd_bus_err = 0; wr_bus_err = 0;
        chan_sel = 0; #1;
        if (rd) chk("R6 read bus error", status_word, ex(0,1,0,0,0,1,20'hC));
        else    chk("R7 write bus error", status_word, ex(0,0,1,0,0,1,20'hC));
        chk(rd ? "R6 go low" : "R7 go low", {31'h0, xfer_go}, 32'h0);
        sts_write(32'h0100_0000);
        chk("R8 bus error cleared", status_word, ex(0,0,0,0,0,0,20'hC));
        clear_all();
    endtask

    task automatic t_countdown(input logic [1:0] sz, input int cnt);
        int left = cnt;
        src_size = sz; dst_size = sz;
        bcr_write(cnt);
        pulse_start();
        chk("R9 REQ while unselected", status_word, ex(0,0,0,1,0,0,20'(cnt)));
        chan_sel = 1; #1;
        chk("R9 REQ low when selected", status_word, ex(0,0,0,0,0,0,20'(cnt)));
        step();
        chk("R9 BSY after select", {status_word[25], xfer_go}, 32'h0000_0003 >> 0 & 32'h0000_0003 ? {30'h0, 2'b11} : 32'h0);
        while (left > 0) begin
            beat_done = 1; step(); beat_done = 0;
            left -= nbytes(sz);
            if (left > 0)
                chk("R10 count step", status_word, ex(0,0,0,0,1,0,20'(left)));
            else
                chk("R10 completion", status_word, ex(0,0,0,0,0,1,20'h0));
        end
        chk("R10 go low at end", {31'h0, xfer_go}, 32'h0);
        chan_sel = 0; clear_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        step();
        t_reset();
        t_range();
        t_zero_start();
        t_align();
        t_badsize();
        t_refuse();
        t_bus_err(1'b1);
        t_bus_err(1'b0);
        t_countdown(2'b00, 12);
        t_countdown(2'b01, 3);
        t_countdown(2'b10, 6);
        chk("R11 reserved at end", status_word & 32'h88F0_0000, 32'h0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule